// File: doc/BRIEF.md
# Four-Way Write-Through Data Cache with Snoop Invalidation

This block is a data cache controller placed between a processor load/store port and a slower main-memory port. Each set holds four lines of 16 bytes, and there are 128 sets. A read is answered in its request cycle when one of the four tags in the addressed set matches. A read miss fetches the whole line in four 32-bit memory beats. The fetch starts with the requested word and wraps around the line. The processor is released as soon as that first word arrives.

Stores never allocate. Each accepted store goes to memory through a one-entry posted buffer. If the line is resident, the cached bytes are updated under the byte enables in the same cycle the store is accepted. A snoop port reports writes made by other bus masters. Any resident line that such a write touches is invalidated, so the next access to it fetches fresh data. Replacement prefers the lowest-numbered empty way. When every way is valid, a three-bit tree pseudo-LRU picks the victim.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset no line is valid, `cpu_ready` and `mem_req` are low, and the first read of any address misses.
- R2: The address is split as byte offset [3:0], word select [3:2], set index [10:4] and tag [31:11]. A read whose tag matches a valid way of its set raises `cpu_ready` in the request cycle, returns the cached word on `cpu_rdata` and issues no memory request.
- R3: A read miss keeps `cpu_ready` low until the fill starts. The fill issues four read beats to word addresses that begin at the requested word and wrap within the line (word w, w+1, … modulo 4). `cpu_ready` rises in the cycle the first beat is acknowledged, with that beat's data on `cpu_rdata`. After the fill the line hits.
- R4: Every accepted store appears on the memory port as exactly one write (`mem_we`=1) with the word-aligned address, data and byte enables of the store.
- R5: A store that hits updates only the bytes whose `cpu_be` bit is set (bit b covers data bits 8b+7..8b). A store that misses allocates nothing, so a later read of that line misses.
- R6: The posted buffer holds one store. A further store is accepted only in the cycle the pending one is acknowledged. A read miss does not start its fill while a store is pending.
- R7: A read miss fills the lowest-numbered invalid way of the set. If all four ways are valid, it fills the way named by the per-set bits {root, left, right}: root=0 picks way 0 or 1 by left, root=1 picks way 2 or 3 by right. Each access to way w sets root to the opposite half and the bit of w's half to point at w's sibling.
- R8: A snoop (`snp_valid` with `snp_addr`) whose set and tag match a valid way clears that way at the next clock edge. The next read of the line misses and returns current memory contents.
- R9: A snoop that matches the line being filled, at any cycle of the fill, leaves that line invalid when the fill ends. The critical word is still delivered.
- R10: While `mem_req` is high and not yet acknowledged, `mem_req`, `mem_we` and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory beat request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = line-fill read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ack | input | 1 | Memory beat done (read data valid) |
| mem_rdata | input | 32 | Memory read data |
| snp_valid | input | 1 | Another master writes `snp_addr` this cycle |
| snp_addr | input | ADDR_W | Address written by the other master |

## Verification
The bench runs a random mix of loads, stores and data-changing snoops. Addresses are drawn from six tags over three sets, so the four ways fill up and the replacement order decides every hit or miss. A bench model of tags and tree bits predicts whether each load completes with zero stall cycles. This separates correct victim choice from a wrong way, and a snooped line from one that was never invalidated. Directed cases add checks the random mix cannot pin down:
- the wrapped beat order of a fill;
- the merge of a partial-byte store;
- a store miss that leaves no line behind;
- a second store stalled behind the one-entry buffer;
- a snoop arriving in the middle of a fill.

// File: rtl/cache_pkg.sv
package cache_pkg;

  localparam int WAYS = 4;

  typedef enum logic {ST_IDLE, ST_FILL} cstate_t;

  // tree bits: [0] root (0 = victim in ways 0/1), [1] left pair, [2] right pair
  function automatic logic [1:0] plru_pick(logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  // point every bit on the path to w away from w
  function automatic logic [2:0] plru_touch(logic [2:0] b, logic [1:0] w);
    logic [2:0] n;
    n = b;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  function automatic logic [1:0] lowest_clear(logic [3:0] v);
    if (!v[0]) return 2'd0;
    if (!v[1]) return 2'd1;
    if (!v[2]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [1:0] hit_index(logic [3:0] h);
    if (h[1]) return 2'd1;
    if (h[2]) return 2'd2;
    if (h[3]) return 2'd3;
    return 2'd0;
  endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 21,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  lk_hit,
  output logic [WAYS-1:0]  lk_valid,
  input  logic             alloc_en,
  input  logic             commit_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_way,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  output logic [WAYS-1:0]  snp_hit
);

  logic [TAG_W-1:0] tags_q  [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];

  always_ff @(posedge clk) begin
    if (alloc_en) tags_q[wr_idx][wr_way] <= alloc_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (alloc_en)  valid_q[wr_idx][wr_way] <= 1'b0;
      if (commit_en) valid_q[wr_idx][wr_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++)
        if (snp_en && snp_hit[w]) valid_q[snp_idx][w] <= 1'b0;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_valid[w] = valid_q[lk_idx][w];
    assign lk_hit[w]   = valid_q[lk_idx][w] && (tags_q[lk_idx][w] == lk_tag);
    assign snp_hit[w]  = valid_q[snp_idx][w] && (tags_q[snp_idx][w] == snp_tag);
  end

  // R2: a tag never sits twice in a set
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit));

  // R8: a snooped line is gone one edge later
  a_r8_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_en && (snp_hit != '0)) |=> ((valid_q[$past(snp_idx)] & $past(snp_hit)) == '0));

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int SETS   = 128,
  parameter int IDX_W  = 7,
  parameter int WPL    = 4,
  parameter int WSEL_W = 2,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [1:0]        w_way,
  input  logic [WSEL_W-1:0] w_word,
  input  logic [3:0]        w_be,
  input  logic [31:0]       w_data,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [1:0]        r_way,
  input  logic [WSEL_W-1:0] r_word,
  output logic [31:0]       r_data
);

  localparam int DEPTH = WAYS * SETS * WPL;
  localparam int AW    = 2 + IDX_W + WSEL_W;

  logic [31:0] words_q [DEPTH];

  logic [AW-1:0] wa, ra;
  assign wa = {w_way, w_idx, w_word};
  assign ra = {r_way, r_idx, r_word};

  always_ff @(posedge clk) begin
    if (we)
      for (int b = 0; b < 4; b++)
        if (w_be[b]) words_q[wa][8*b +: 8] <= w_data[8*b +: 8];
  end

  assign r_data = words_q[ra];

endmodule

// File: rtl/cache_plru.sv
module cache_plru #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       touch_way,
  output logic [2:0]       bits
);
  import cache_pkg::*;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[idx] <= plru_touch(tree_q[idx], touch_way);
    end
  end

  assign bits = tree_q[idx];

endmodule

// File: rtl/cache_wbuf.sv
module cache_wbuf #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [31:0]       push_data,
  input  logic [3:0]        push_be,
  input  logic              pop,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       data,
  output logic [3:0]        be
);

  always_ff @(posedge clk) begin
    if (!rst_n) valid <= 1'b0;
    else if (push) valid <= 1'b1;
    else if (pop)  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr <= push_addr;
      data <= push_data;
      be   <= push_be;
    end
  end

  // R6: a held store is never overwritten before it leaves
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!valid || pop));

endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic [3:0]        cpu_be,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  import cache_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WPL    = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(WPL);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPL - 1);

  // request fields (R2)
  logic [IDX_W-1:0]  req_idx, snp_idx;
  logic [TAG_W-1:0]  req_tag, snp_tag;
  logic [WSEL_W-1:0] req_word;
  assign req_idx  = cpu_addr[OFF_W +: IDX_W];
  assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_word = cpu_addr[2 +: WSEL_W];
  assign snp_idx  = snp_addr[OFF_W +: IDX_W];
  assign snp_tag  = snp_addr[ADDR_W-1 -: TAG_W];

  // fill context
  cstate_t           state_q;
  logic [IDX_W-1:0]  f_idx_q;
  logic [TAG_W-1:0]  f_tag_q;
  logic [1:0]        f_way_q;
  logic [WSEL_W-1:0] f_word_q;
  logic [WSEL_W-1:0] beat_q;
  logic              kill_q;

  // named internal events
  logic [WAYS-1:0]   hit_vec, valid_vec, snp_hit;
  logic              hit, idle;
  logic [1:0]        hit_way, victim;
  logic [2:0]        tree_bits;
  logic              wb_valid, wb_pop;
  logic [ADDR_W-1:0] wb_addr;
  logic [31:0]       wb_data, rd_data;
  logic [3:0]        wb_be;
  logic              rd_hit, wr_go, wr_hit, miss_go;
  logic              beat_ack, crit_ack, last_ack;
  logic              snp_on_fill, snp_on_start, commit;
  logic [WSEL_W-1:0] fill_word;

  assign idle      = (state_q == ST_IDLE);
  assign hit       = |hit_vec;
  assign hit_way   = hit_index(hit_vec);
  assign victim    = (&valid_vec) ? plru_pick(tree_bits) : lowest_clear(valid_vec);
  assign fill_word = f_word_q + beat_q;

  assign wb_pop   = idle && wb_valid && mem_ack;
  assign rd_hit   = idle && cpu_req && !cpu_we && hit;
  assign wr_go    = idle && cpu_req && cpu_we && (!wb_valid || wb_pop);
  assign wr_hit   = wr_go && hit;
  assign miss_go  = idle && cpu_req && !cpu_we && !hit && !wb_valid;
  assign beat_ack = !idle && mem_ack;
  assign crit_ack = beat_ack && (beat_q == '0);
  assign last_ack = beat_ack && (beat_q == LAST_BEAT);

  // R9: snoop against the line in flight
  assign snp_on_fill  = !idle && snp_valid && (snp_idx == f_idx_q) && (snp_tag == f_tag_q);
  assign snp_on_start = miss_go && snp_valid && (snp_idx == req_idx) && (snp_tag == req_tag);
  assign commit       = last_ack && !kill_q && !snp_on_fill;

  assign cpu_ready = rd_hit || wr_go || crit_ack;
  assign cpu_rdata = idle ? rd_data : mem_rdata;

  assign mem_req   = !idle || wb_valid;
  assign mem_we    = idle;
  assign mem_addr  = idle ? wb_addr : {f_tag_q, f_idx_q, fill_word, 2'b00};
  assign mem_wdata = wb_data;
  assign mem_be    = idle ? wb_be : 4'hF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      kill_q  <= 1'b0;
    end else if (idle) begin
      if (miss_go) begin
        state_q  <= ST_FILL;
        beat_q   <= '0;
        kill_q   <= snp_on_start;
        f_idx_q  <= req_idx;
        f_tag_q  <= req_tag;
        f_way_q  <= victim;
        f_word_q <= req_word;
      end
    end else begin
      if (snp_on_fill) kill_q <= 1'b1;
      if (beat_ack) beat_q <= beat_q + 1'b1;
      if (last_ack) state_q <= ST_IDLE;
    end
  end

  cache_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (req_idx),
    .lk_tag    (req_tag),
    .lk_hit    (hit_vec),
    .lk_valid  (valid_vec),
    .alloc_en  (miss_go),
    .commit_en (commit),
    .wr_idx    (idle ? req_idx : f_idx_q),
    .wr_way    (idle ? victim : f_way_q),
    .alloc_tag (req_tag),
    .snp_en    (snp_valid),
    .snp_idx   (snp_idx),
    .snp_tag   (snp_tag),
    .snp_hit   (snp_hit)
  );

  cache_data_store #(.SETS(SETS), .IDX_W(IDX_W), .WPL(WPL), .WSEL_W(WSEL_W), .WAYS(WAYS)) u_data (
    .clk    (clk),
    .we     (beat_ack || wr_hit),
    .w_idx  (idle ? req_idx : f_idx_q),
    .w_way  (idle ? hit_way : f_way_q),
    .w_word (idle ? req_word : fill_word),
    .w_be   (idle ? cpu_be : 4'hF),
    .w_data (idle ? cpu_wdata : mem_rdata),
    .r_idx  (req_idx),
    .r_way  (hit_way),
    .r_word (req_word),
    .r_data (rd_data)
  );

  cache_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (rd_hit || wr_hit || miss_go),
    .idx       (req_idx),
    .touch_way (miss_go ? victim : hit_way),
    .bits      (tree_bits)
  );

  cache_wbuf #(.ADDR_W(ADDR_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_go),
    .push_addr ({cpu_addr[ADDR_W-1:2], 2'b00}),
    .push_data (cpu_wdata),
    .push_be   (cpu_be),
    .pop       (wb_pop),
    .valid     (wb_valid),
    .addr      (wb_addr),
    .data      (wb_data),
    .be        (wb_be)
  );

  // R10: an outstanding beat holds still
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3: a missing load is never released from the lookup
  a_r3_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cpu_req && !cpu_we && !hit) |-> !cpu_ready);

  // R6: fills read memory only once the store buffer is empty
  a_r6_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !wb_valid);

endmodule

// File: tb/sim_snoop_wt_cache.sv
module sim_snoop_wt_cache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0]  cpu_be = 0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic        snp_valid = 0;
  logic [31:0] snp_addr = 0;

  always #5 clk = ~clk;

  snoop_wt_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  int total = 0, bad = 0;

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, expv);
    end
  endtask

  // ---------------- memory contents ----------------
  logic [31:0] bmem    [logic [31:0]];
  logic [31:0] exp_mem [logic [31:0]];

  function automatic logic [31:0] seed_word(logic [31:0] a);
    return (a * 32'h01000193) ^ 32'h13579BDF;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] get_b(logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : seed_word(a);
  endfunction

  function automatic logic [31:0] get_e(logic [31:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : seed_word(a);
  endfunction

  // ---------------- memory responder ----------------
  int          lat_force = -1;
  int          lat_cnt = 0;
  bit          waiting = 0, hold_bad = 0;
  logic [31:0] prev_addr;
  int          wr_cnt = 0, rd_cnt = 0;
  logic [31:0] last_wa, last_wd;
  logic [3:0]  last_wbe;
  logic [31:0] rd_log [8];

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (!waiting) begin
        waiting   = 1;
        lat_cnt   = (lat_force >= 0) ? lat_force : int'($urandom % 3);
        prev_addr = mem_addr;
      end else if (mem_addr != prev_addr) begin
        hold_bad = 1;
      end
      if (lat_cnt == 0) begin
        mem_ack = 1'b1;
        waiting = 0;
        if (mem_we) begin
          bmem[mem_addr] = merge(get_b(mem_addr), mem_wdata, mem_be);
          last_wa = mem_addr; last_wd = mem_wdata; last_wbe = mem_be;
          wr_cnt++;
        end else begin
          mem_rdata = get_b(mem_addr);
          rd_log[rd_cnt % 8] = mem_addr;
          rd_cnt++;
        end
      end else begin
        lat_cnt--;
      end
    end
  end

  // ---------------- cache model ----------------
  logic [20:0] m_tag [128][4];
  bit          m_val [128][4];
  bit   [2:0]  m_lru [128];

  function automatic bit [1:0] b_victim(bit [2:0] t);
    if (t[0] == 1'b0) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic bit [2:0] b_touch(bit [2:0] t, bit [1:0] w);
    bit [2:0] n;
    n = t;
    case (w)
      2'd0: begin n[0] = 1; n[1] = 1; end
      2'd1: begin n[0] = 1; n[1] = 0; end
      2'd2: begin n[0] = 0; n[2] = 1; end
      default: begin n[0] = 0; n[2] = 0; end
    endcase
    return n;
  endfunction

  task automatic model_find(logic [31:0] a, output bit h, output int w);
    int s;
    s = int'(a[10:4]);
    h = 0; w = 0;
    for (int i = 0; i < 4; i++)
      if (m_val[s][i] && m_tag[s][i] == a[31:11]) begin h = 1; w = i; end
  endtask

  task automatic model_read(logic [31:0] a, output bit h);
    int s, w;
    s = int'(a[10:4]);
    model_find(a, h, w);
    if (!h) begin
      w = -1;
      for (int i = 3; i >= 0; i--) if (!m_val[s][i]) w = i;
      if (w < 0) w = int'(b_victim(m_lru[s]));
      m_tag[s][w] = a[31:11];
      m_val[s][w] = 1;
    end
    m_lru[s] = b_touch(m_lru[s], 2'(w));
  endtask

  task automatic model_write(logic [31:0] a);
    bit h; int w;
    model_find(a, h, w);
    if (h) m_lru[int'(a[10:4])] = b_touch(m_lru[int'(a[10:4])], 2'(w));
  endtask

  task automatic model_snoop(logic [31:0] a);
    bit h; int w;
    model_find(a, h, w);
    if (h) m_val[int'(a[10:4])][w] = 0;
  endtask

  // ---------------- processor tasks ----------------
  task automatic do_read(logic [31:0] a, output logic [31:0] d, output int stalls);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    stalls = 0;
    forever begin
      #4;
      if (cpu_ready) begin d = cpu_rdata; break; end
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 0;
    while (mem_req && !mem_we) @(negedge clk);
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] d, logic [3:0] be, output int stalls);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    stalls = 0;
    forever begin
      #4;
      if (cpu_ready) break;
      stalls++;
      @(negedge clk);
    end
    exp_mem[{a[31:2], 2'b00}] = merge(get_e({a[31:2], 2'b00}), d, be);
    model_write(a);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic drain();
    while (mem_req) @(negedge clk);
  endtask

  task automatic do_snoop(logic [31:0] a, bit change);
    logic [31:0] wa, nv;
    drain();
    @(negedge clk);
    wa = {a[31:2], 2'b00};
    snp_valid = 1; snp_addr = a;
    if (change) begin
      nv = $urandom;
      bmem[wa] = nv;
      exp_mem[wa] = nv;
    end
    @(negedge clk);
    snp_valid = 0;
    model_snoop(a);
  endtask

  // read with data check and hit/miss check; want_hit < 0 takes the model
  task automatic rd_chk(logic [31:0] a, int want_hit, string rq_hit);
    logic [31:0] d, e;
    int st;
    bit mh, eh;
    e = get_e({a[31:2], 2'b00});
    do_read(a, d, st);
    model_read(a, mh);
    eh = (want_hit < 0) ? mh : bit'(want_hit);
    check(d == e, "R3 load data", d, e);
    check((st == 0) == eh, rq_hit, 32'(st), {31'd0, eh});
  endtask

  function automatic logic [31:0] mk(int tg, int st, int wd);
    return (32'(tg) << 11) | (32'(st) << 4) | (32'(wd) << 2);
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog act=%0d exp=%0d", 150000, 0);
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] a, b, d, e, w0;
    int st, n0;
    void'($urandom(32'd20240611));
    rst_n = 0;
    repeat (3) @(negedge clk);
    #4;
    check(!cpu_ready && !mem_req, "R1 outputs in reset", {cpu_ready, mem_req}, 0);
    @(negedge clk);
    rst_n = 1;
    #4;
    check(!cpu_ready && !mem_req, "R1 outputs after reset", {cpu_ready, mem_req}, 0);

    // R1/R3: cold miss, wrapped fill starting at word 2
    lat_force = 1;
    a = mk(9, 10, 2);
    n0 = rd_cnt;
    rd_chk(a, 0, "R1 cold read misses");
    check(rd_cnt - n0 == 4, "R3 four fill beats", 32'(rd_cnt - n0), 4);
    check(rd_log[(n0 + 0) % 8] == mk(9, 10, 2), "R3 beat0 addr", rd_log[(n0 + 0) % 8], mk(9, 10, 2));
    check(rd_log[(n0 + 1) % 8] == mk(9, 10, 3), "R3 beat1 addr", rd_log[(n0 + 1) % 8], mk(9, 10, 3));
    check(rd_log[(n0 + 2) % 8] == mk(9, 10, 0), "R3 beat2 addr", rd_log[(n0 + 2) % 8], mk(9, 10, 0));
    check(rd_log[(n0 + 3) % 8] == mk(9, 10, 1), "R3 beat3 addr", rd_log[(n0 + 3) % 8], mk(9, 10, 1));

    // R2: hits on the filled line, no memory request
    rd_chk(mk(9, 10, 0), 1, "R2 hit after fill");
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = mk(9, 10, 3); #4;
    check(cpu_ready && !mem_req && cpu_rdata == get_e(mk(9, 10, 3)), "R2 same-cycle hit",
          cpu_rdata, get_e(mk(9, 10, 3)));
    @(negedge clk); cpu_req = 0;

    // R4/R5: partial store on a resident line
    w0 = get_e(a);
    n0 = wr_cnt;
    do_write(a | 32'd1, 32'hDEADBEEF, 4'b0101, st);
    drain();
    check(wr_cnt - n0 == 1, "R4 one memory write", 32'(wr_cnt - n0), 1);
    check(last_wa == a, "R4 write addr", last_wa, a);
    check(last_wd == 32'hDEADBEEF, "R4 write data", last_wd, 32'hDEADBEEF);
    check(last_wbe == 4'b0101, "R4 write be", {28'd0, last_wbe}, 32'h5);
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = a; #4;
    e = merge(w0, 32'hDEADBEEF, 4'b0101);
    check(cpu_ready && cpu_rdata == e, "R5 byte merge on hit", cpu_rdata, e);
    @(negedge clk); cpu_req = 0;
    model_write(a);

    // R5: store miss does not allocate
    b = mk(11, 20, 1);
    do_write(b, 32'h12345678, 4'hF, st);
    drain();
    rd_chk(b, 0, "R5 no allocate on store miss");

    // R6: second store waits behind the pending one
    lat_force = 2;
    do_write(mk(12, 21, 0), 32'h11111111, 4'hF, st);
    do_write(mk(12, 21, 1), 32'h22222222, 4'hF, st);
    check(st > 0, "R6 second store stalls", 32'(st), 1);
    rd_chk(mk(13, 21, 0), 0, "R6 miss after stores");
    rd_chk(mk(12, 21, 1), 0, "R6 store data reached memory");

    // R7: replacement order in set 5
    lat_force = -1;
    for (int t = 1; t <= 4; t++) rd_chk(mk(t, 5, 0), 0, "R7 invalid way first");
    rd_chk(mk(5, 5, 0), 0, "R7 fifth tag misses");
    rd_chk(mk(2, 5, 1), 1, "R7 tag2 kept");
    rd_chk(mk(1, 5, 2), 0, "R7 tag1 was the victim");
    rd_chk(mk(3, 5, 0), 0, "R7 tag3 evicted by tag1");
    rd_chk(mk(4, 5, 3), 1, "R7 tag4 kept");

    // R8: snoop invalidates, reload sees new data
    rd_chk(mk(7, 30, 1), 0, "R8 setup fill");
    do_snoop(mk(7, 30, 1) | 32'd2, 1);
    rd_chk(mk(7, 30, 1), 0, "R8 snooped line misses");
    rd_chk(mk(7, 30, 1), 1, "R8 refill hits");

    // R9: snoop while the line is being filled
    lat_force = 2;
    a = mk(8, 40, 3);
    fork
      rd_chk(a, 0, "R9 fill miss");
      begin
        @(negedge clk);
        while (!(mem_req && !mem_we)) @(negedge clk);
        repeat (3) @(negedge clk);
        snp_valid = 1; snp_addr = mk(8, 40, 0);
        @(negedge clk);
        snp_valid = 0;
      end
    join
    model_snoop(a);
    rd_chk(a, 0, "R9 killed fill left line invalid");
    lat_force = -1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 100);
      a = mk(1 + int'($urandom % 6), 60 + int'($urandom % 3), int'($urandom % 4));
      if (r < 60)      rd_chk(a, -1, "R7 random hit/miss");
      else if (r < 85) do_write(a, $urandom, 4'($urandom), st);
      else             do_snoop(a | 32'($urandom % 4), 1);
    end

    drain();
    check(!hold_bad, "R10 request held until ack", {31'd0, hold_bad}, 0);
    finish_run();
  end

endmodule